// File: doc/BRIEF.md
# Operand Address Generation Unit

This unit turns the 8-bit operand-location field of an instruction into a data-memory address. It also applies any stack-pointer or pointer-register adjustment that the encoding asks for. A held mode bit picks one of two decode maps for the same field.

The default map (mode 0) offers:
- page-relative addressing with a 6-bit offset,
- a frame-style mode that addresses below the stack pointer,
- pointer-plus-small-constant addressing.

The alternate map (mode 1) gives up those forms in exchange for a 7-bit page offset.

Both maps share the following forms:
- stack push/pop style accesses,
- pointer post-increment and pre-decrement,
- pointer-plus-index accesses that use the low halves of pointers 0 and 1 as indexes.

The unit holds eight 32-bit pointer registers and a stack pointer. A load port writes these registers and the mode bit directly. A decode request is presented together with a strobe. One clock later the unit produces either an address-valid pulse with the address, or an illegal-encoding pulse. Register adjustments land on that same clock edge.

Top module: `oper_agu`

## Requirements
- R1: After reset the mode bit reads 0, `addr_vld_o` and `illegal_o` are 0, and the stack pointer and all eight pointer registers hold 0.
- R2: In mode 0, a field `00 oooooo` yields the address (page × 64) + o, truncated to 22 bits.
- R3: In mode 1, a field `0 ooooooo` yields the address (page × 128) + o, truncated to 22 bits.
- R4: In mode 0, a field `01 oooooo` yields SP − o, and SP is left unchanged.
- R5: In both modes, field `10111101` addresses SP and then adds the step to SP. Field `10111110` subtracts the step from SP and then addresses the new SP. The step is 1 when `size32_i`=0 and 2 when `size32_i`=1.
- R6: In both modes, field `10000ppp` addresses pointer p and then adds the step to it. Field `10001ppp` subtracts the step from pointer p and then addresses it. The address is the low 22 bits of the pointer.
- R7: In both modes, field `10010ppp` addresses pointer p plus the zero-extended low 16 bits of pointer 0. Field `10011ppp` uses the low 16 bits of pointer 1 instead. Pointer p is not modified.
- R8: In mode 0, field `11 kkk ppp` addresses pointer p plus the unsigned value k, with no register change.
- R9: Any field not defined for the current mode raises `illegal_o` for one cycle, keeps `addr_vld_o` low, and leaves SP and all pointers unchanged. This covers `11xxxxxx` in mode 1 and every `101xxxxx` except `10111101` and `10111110`.
- R10: `addr_vld_o` or `illegal_o` pulses exactly one cycle after a cycle with `dec_valid_i` high, and never otherwise. Register adjustments become visible on that same edge.
- R11: With `ld_en_i` high, register `ld_sel_i` is written on the next edge: values 0–7 select a pointer, and 8 selects SP, which takes the low 16 bits. With `mode_ld_i` high, the mode bit takes `mode_val_i` on the next edge.
- R12: All pointer and SP arithmetic wraps modulo the register width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_ld_i | input | 1 | Load the mode bit |
| mode_val_i | input | 1 | New mode bit value |
| dec_valid_i | input | 1 | Decode request strobe |
| loc_i | input | 8 | Operand-location field |
| size32_i | input | 1 | 1 = 32-bit access (step 2), 0 = 16-bit (step 1) |
| dp_i | input | 16 | Data page pointer |
| ld_en_i | input | 1 | Register load enable |
| ld_sel_i | input | 4 | Load target: 0–7 pointer, 8 SP |
| ld_data_i | input | 32 | Load value |
| mode_o | output | 1 | Current mode bit |
| addr_o | output | 22 | Effective address, meaningful while `addr_vld_o` is high |
| addr_vld_o | output | 1 | Address-valid pulse |
| illegal_o | output | 1 | Illegal-encoding pulse |

## Verification
Every result appears one clock after its strobe: the address, the valid pulse, the illegal pulse and any register adjustment all land on that edge. The bench drives the strobe just after a rising edge, drops it after the next rising edge, and samples the outputs 1 ns later. One edge later it confirms that both pulses have gone low. The adjusted registers are read back through the unit's own decode path: mode 0 pointer-plus-zero for a pointer, and SP-minus-zero for the stack pointer. Each such probe is a further strobe with its own one-cycle latency. The sweep covers all 256 field values in both modes and at both access sizes, starting each time from freshly loaded registers.

// File: rtl/agu_pkg.sv
package agu_pkg;

    localparam int NPTR   = 8;
    localparam int PSEL_W = $clog2(NPTR);

    typedef enum logic [3:0] {
        K_DIRECT6,
        K_DIRECT7,
        K_STKREL,
        K_SP_POSTINC,
        K_SP_PREDEC,
        K_PTR_POSTINC,
        K_PTR_PREDEC,
        K_PTR_IDX0,
        K_PTR_IDX1,
        K_PTR_IMM,
        K_ILLEGAL
    } agu_kind_e;

    typedef struct packed {
        agu_kind_e         kind;
        logic [PSEL_W-1:0] ptr;
        logic [6:0]        offs;
    } agu_dec_t;

    // decode of the shared 10 xxx xxx group, identical in both maps
    function automatic agu_kind_e grp10_kind(input logic [5:0] b);
        agu_kind_e k;
        case (b[5:3])
            3'b000:  k = K_PTR_POSTINC;
            3'b001:  k = K_PTR_PREDEC;
            3'b010:  k = K_PTR_IDX0;
            3'b011:  k = K_PTR_IDX1;
            3'b111: begin
                if (b[2:0] == 3'b101)      k = K_SP_POSTINC;
                else if (b[2:0] == 3'b110) k = K_SP_PREDEC;
                else                       k = K_ILLEGAL;
            end
            default: k = K_ILLEGAL;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/agu_decode.sv
module agu_decode
    import agu_pkg::*;
(
    input  logic       mode_i,
    input  logic [7:0] loc_i,
    output agu_dec_t   dec_o
);

    always_comb begin
        dec_o.kind = K_ILLEGAL;
        dec_o.ptr  = loc_i[PSEL_W-1:0];
        dec_o.offs = loc_i[6:0];
        if (!mode_i) begin
            case (loc_i[7:6])
                2'b00:   dec_o.kind = K_DIRECT6;
                2'b01:   dec_o.kind = K_STKREL;
                2'b10:   dec_o.kind = grp10_kind(loc_i[5:0]);
                default: dec_o.kind = K_PTR_IMM;
            endcase
        end else begin
            if (!loc_i[7])      dec_o.kind = K_DIRECT7;
            else if (!loc_i[6]) dec_o.kind = grp10_kind(loc_i[5:0]);
            else                dec_o.kind = K_ILLEGAL;
        end
    end

endmodule

// File: rtl/agu_addr.sv
module agu_addr
    import agu_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int PTR_W  = 32,
    parameter int SP_W   = 16,
    parameter int DP_W   = 16,
    parameter int IDX_W  = 16
) (
    input  agu_dec_t                   dec_i,
    input  logic                       size32_i,
    input  logic [DP_W-1:0]            dp_i,
    input  logic [NPTR-1:0][PTR_W-1:0] xar_i,
    input  logic [SP_W-1:0]            sp_i,
    output logic [ADDR_W-1:0]          addr_o,
    output logic                       legal_o,
    output logic                       ptr_we_o,
    output logic [PTR_W-1:0]           ptr_val_o,
    output logic                       sp_we_o,
    output logic [SP_W-1:0]            sp_val_o
);

    logic [PTR_W-1:0] xsel;
    logic [PTR_W-1:0] idx0;
    logic [PTR_W-1:0] idx1;
    logic [PTR_W-1:0] pstep;
    logic [SP_W-1:0]  sstep;

    always_comb begin
        xsel  = xar_i[dec_i.ptr];
        idx0  = PTR_W'(xar_i[0][IDX_W-1:0]);
        idx1  = PTR_W'(xar_i[1][IDX_W-1:0]);
        pstep = size32_i ? PTR_W'(2) : PTR_W'(1);
        sstep = size32_i ? SP_W'(2)  : SP_W'(1);

        addr_o    = '0;
        legal_o   = 1'b1;
        ptr_we_o  = 1'b0;
        ptr_val_o = xsel;
        sp_we_o   = 1'b0;
        sp_val_o  = sp_i;

        case (dec_i.kind)
            K_DIRECT6: addr_o = ADDR_W'({dp_i, dec_i.offs[5:0]});
            K_DIRECT7: addr_o = ADDR_W'({dp_i, dec_i.offs});
            K_STKREL:  addr_o = ADDR_W'(sp_i - SP_W'(dec_i.offs[5:0]));
            K_SP_POSTINC: begin
                addr_o   = ADDR_W'(sp_i);
                sp_we_o  = 1'b1;
                sp_val_o = sp_i + sstep;
            end
            K_SP_PREDEC: begin
                sp_we_o  = 1'b1;
                sp_val_o = sp_i - sstep;
                addr_o   = ADDR_W'(sp_val_o);
            end
            K_PTR_POSTINC: begin
                addr_o    = ADDR_W'(xsel);
                ptr_we_o  = 1'b1;
                ptr_val_o = xsel + pstep;
            end
            K_PTR_PREDEC: begin
                ptr_we_o  = 1'b1;
                ptr_val_o = xsel - pstep;
                addr_o    = ADDR_W'(ptr_val_o);
            end
            K_PTR_IDX0: addr_o = ADDR_W'(xsel + idx0);
            K_PTR_IDX1: addr_o = ADDR_W'(xsel + idx1);
            K_PTR_IMM:  addr_o = ADDR_W'(xsel + PTR_W'(dec_i.offs[5:3]));
            default:    legal_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/agu_regs.sv
module agu_regs
    import agu_pkg::*;
#(
    parameter int PTR_W    = 32,
    parameter int SP_W     = 16,
    parameter int LDSEL_W  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ptr_we_i,
    input  logic [PSEL_W-1:0]          ptr_sel_i,
    input  logic [PTR_W-1:0]           ptr_val_i,
    input  logic                       sp_we_i,
    input  logic [SP_W-1:0]            sp_val_i,
    input  logic                       ld_en_i,
    input  logic [LDSEL_W-1:0]         ld_sel_i,
    input  logic [PTR_W-1:0]           ld_data_i,
    output logic [NPTR-1:0][PTR_W-1:0] xar_o,
    output logic [SP_W-1:0]            sp_o
);

    localparam logic [LDSEL_W-1:0] SP_SEL = LDSEL_W'(NPTR);

    typedef struct packed {
        logic [NPTR-1:0][PTR_W-1:0] xar;
        logic [SP_W-1:0]            sp;
    } regs_t;

    regs_t            regs_d, regs_q;
    logic [PTR_W-1:0] xar_nxt [NPTR];

    // per-pointer next value: load port overrides a decode update
    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        assign xar_nxt[g] =
            (ld_en_i && ld_sel_i == LDSEL_W'(g))    ? ld_data_i :
            (ptr_we_i && ptr_sel_i == PSEL_W'(g))   ? ptr_val_i :
                                                      regs_q.xar[g];
    end

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < NPTR; i++) begin
            regs_d.xar[i] = xar_nxt[i];
        end
        if (sp_we_i) regs_d.sp = sp_val_i;
        if (ld_en_i && ld_sel_i == SP_SEL) regs_d.sp = SP_W'(ld_data_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign xar_o = regs_q.xar;
    assign sp_o  = regs_q.sp;

endmodule

// File: rtl/oper_agu.sv
module oper_agu
    import agu_pkg::*;
#(
    parameter int ADDR_W  = 22,
    parameter int PTR_W   = 32,
    parameter int SP_W    = 16,
    parameter int DP_W    = 16,
    parameter int LDSEL_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_ld_i,
    input  logic               mode_val_i,
    input  logic               dec_valid_i,
    input  logic [7:0]         loc_i,
    input  logic               size32_i,
    input  logic [DP_W-1:0]    dp_i,
    input  logic               ld_en_i,
    input  logic [LDSEL_W-1:0] ld_sel_i,
    input  logic [PTR_W-1:0]   ld_data_i,
    output logic               mode_o,
    output logic [ADDR_W-1:0]  addr_o,
    output logic               addr_vld_o,
    output logic               illegal_o
);

    localparam int IDX_W = PTR_W / 2;

    typedef struct packed {
        logic              mode;
        logic              vld;
        logic              ill;
        logic [ADDR_W-1:0] addr;
    } out_t;

    out_t                       out_d, out_q;
    agu_dec_t                   dec;
    logic [NPTR-1:0][PTR_W-1:0] xar_w;
    logic [SP_W-1:0]            sp_w;
    logic [ADDR_W-1:0]          addr_c;
    logic                       legal_c;
    logic                       ptr_we_c;
    logic [PTR_W-1:0]           ptr_val_c;
    logic                       sp_we_c;
    logic [SP_W-1:0]            sp_val_c;

    agu_decode u_dec (
        .mode_i (out_q.mode),
        .loc_i  (loc_i),
        .dec_o  (dec)
    );

    agu_addr #(
        .ADDR_W (ADDR_W),
        .PTR_W  (PTR_W),
        .SP_W   (SP_W),
        .DP_W   (DP_W),
        .IDX_W  (IDX_W)
    ) u_addr (
        .dec_i     (dec),
        .size32_i  (size32_i),
        .dp_i      (dp_i),
        .xar_i     (xar_w),
        .sp_i      (sp_w),
        .addr_o    (addr_c),
        .legal_o   (legal_c),
        .ptr_we_o  (ptr_we_c),
        .ptr_val_o (ptr_val_c),
        .sp_we_o   (sp_we_c),
        .sp_val_o  (sp_val_c)
    );

    agu_regs #(
        .PTR_W   (PTR_W),
        .SP_W    (SP_W),
        .LDSEL_W (LDSEL_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ptr_we_i  (dec_valid_i & ptr_we_c),
        .ptr_sel_i (dec.ptr),
        .ptr_val_i (ptr_val_c),
        .sp_we_i   (dec_valid_i & sp_we_c),
        .sp_val_i  (sp_val_c),
        .ld_en_i   (ld_en_i),
        .ld_sel_i  (ld_sel_i),
        .ld_data_i (ld_data_i),
        .xar_o     (xar_w),
        .sp_o      (sp_w)
    );

    always_comb begin
        out_d     = out_q;
        out_d.vld = dec_valid_i & legal_c;
        out_d.ill = dec_valid_i & ~legal_c;
        if (dec_valid_i && legal_c) out_d.addr = addr_c;
        if (mode_ld_i)              out_d.mode = mode_val_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign mode_o     = out_q.mode;
    assign addr_o     = out_q.addr;
    assign addr_vld_o = out_q.vld;
    assign illegal_o  = out_q.ill;

endmodule

// File: rtl/agu_chk.sv
module agu_chk #(
    parameter int SP_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            dec_valid_i,
    input logic [7:0]      loc_i,
    input logic            size32_i,
    input logic            ld_en_i,
    input logic            mode_ld_i,
    input logic            mode_q,
    input logic [SP_W-1:0] sp_q,
    input logic            addr_vld_o,
    input logic            illegal_o
);

    // R10
    one_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_vld_o && illegal_o));

    // R10
    vld_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_vld_o || illegal_o) |-> $past(dec_valid_i));

    // R9
    mode1_upper_ill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_i && mode_q && loc_i[7:6] == 2'b11) |=> illegal_o);

    // R9
    ill_keeps_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal_o && !$past(ld_en_i)) |-> $stable(sp_q));

    // R4
    stkrel_keeps_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_i && !mode_q && loc_i[7:6] == 2'b01 && !ld_en_i) |=> $stable(sp_q));

    // R5
    sp_postinc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_i && loc_i == 8'hBD && !size32_i && !ld_en_i) |=> sp_q == $past(sp_q) + SP_W'(1));

    // R11
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(mode_ld_i) |-> $stable(mode_q));

endmodule

bind oper_agu agu_chk #(.SP_W(SP_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dec_valid_i (dec_valid_i),
    .loc_i       (loc_i),
    .size32_i    (size32_i),
    .ld_en_i     (ld_en_i),
    .mode_ld_i   (mode_ld_i),
    .mode_q      (mode_o),
    .sp_q        (sp_w),
    .addr_vld_o  (addr_vld_o),
    .illegal_o   (illegal_o)
);

// File: tb/tb_oper_agu.sv
module tb_oper_agu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_ld_i = 1'b0;
    logic        mode_val_i = 1'b0;
    logic        dec_valid_i = 1'b0;
    logic [7:0]  loc_i = '0;
    logic        size32_i = 1'b0;
    logic [15:0] dp_i = '0;
    logic        ld_en_i = 1'b0;
    logic [3:0]  ld_sel_i = '0;
    logic [31:0] ld_data_i = '0;
    logic        mode_o;
    logic [21:0] addr_o;
    logic        addr_vld_o;
    logic        illegal_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [31:0] bx [8];
    logic [15:0] bsp;

    always #4 clk = ~clk;

    oper_agu dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_ld_i   (mode_ld_i),
        .mode_val_i  (mode_val_i),
        .dec_valid_i (dec_valid_i),
        .loc_i       (loc_i),
        .size32_i    (size32_i),
        .dp_i        (dp_i),
        .ld_en_i     (ld_en_i),
        .ld_sel_i    (ld_sel_i),
        .ld_data_i   (ld_data_i),
        .mode_o      (mode_o),
        .addr_o      (addr_o),
        .addr_vld_o  (addr_vld_o),
        .illegal_o   (illegal_o)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic load_reg(input logic [3:0] sel, input logic [31:0] val);
        ld_en_i = 1'b1; ld_sel_i = sel; ld_data_i = val;
        tick();
        ld_en_i = 1'b0;
    endtask

    task automatic set_mode(input logic m);
        mode_ld_i = 1'b1; mode_val_i = m;
        tick();
        mode_ld_i = 1'b0;
    endtask

    // strobe one field; outputs are sampled 1 ns after the next edge
    task automatic issue(input logic [7:0] code, input logic sz,
                         output logic [21:0] a, output logic v, output logic il);
        dec_valid_i = 1'b1; loc_i = code; size32_i = sz;
        tick();
        dec_valid_i = 1'b0;
        a = addr_o; v = addr_vld_o; il = illegal_o;
    endtask

    task automatic probe(input logic [7:0] code, output logic [21:0] a);
        logic v, il;
        issue(code, 1'b0, a, v, il);
    endtask

    // bench model of one decode
    task automatic model(input logic m, input logic sz, input logic [7:0] l,
                         output logic e_vld, output logic e_ill, output logic [21:0] e_addr,
                         output logic [15:0] e_sp, output logic [31:0] e_x, output string tag);
        logic [31:0] xs;
        logic [31:0] st;
        xs = bx[l[2:0]];
        st = sz ? 32'd2 : 32'd1;
        e_sp = bsp; e_x = xs; e_vld = 1'b1; e_ill = 1'b0; e_addr = '0;
        if (!m && l[7:6] == 2'b00) begin
            tag = "R2"; e_addr = 22'(32'(dp_i) * 64 + 32'(l[5:0]));
        end else if (m && !l[7]) begin
            tag = "R3"; e_addr = 22'(32'(dp_i) * 128 + 32'(l[6:0]));
        end else if (!m && l[7:6] == 2'b01) begin
            tag = "R4"; e_addr = 22'(16'(bsp - 16'(l[5:0])));
        end else if (l == 8'hBD) begin
            tag = "R5"; e_addr = 22'(bsp); e_sp = bsp + 16'(st);
        end else if (l == 8'hBE) begin
            tag = "R5"; e_sp = bsp - 16'(st); e_addr = 22'(e_sp);
        end else if (l[7:3] == 5'b10000) begin
            tag = "R6"; e_addr = xs[21:0]; e_x = xs + st;
        end else if (l[7:3] == 5'b10001) begin
            tag = "R6"; e_x = xs - st; e_addr = e_x[21:0];
        end else if (l[7:3] == 5'b10010) begin
            tag = "R7"; e_addr = 22'(xs + {16'h0, bx[0][15:0]});
        end else if (l[7:3] == 5'b10011) begin
            tag = "R7"; e_addr = 22'(xs + {16'h0, bx[1][15:0]});
        end else if (!m && l[7:6] == 2'b11) begin
            tag = "R8"; e_addr = 22'(xs + 32'(l[5:3]));
        end else begin
            tag = "R9"; e_vld = 1'b0; e_ill = 1'b1;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R10 watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [21:0] a;
        logic        v, il;
        logic        e_vld, e_ill;
        logic [21:0] e_addr;
        logic [15:0] e_sp;
        logic [31:0] e_x;
        string       tag;

        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R1 reset state
        check("R1", "mode", 32'(mode_o), 0);
        check("R1", "vld", 32'(addr_vld_o), 0);
        check("R1", "ill", 32'(illegal_o), 0);
        probe(8'h40, a);
        check("R1", "sp", 32'(a), 0);
        probe(8'hC3, a);
        check("R1", "xar3", 32'(a), 0);

        // R11 load port and mode load
        load_reg(4'd6, 32'h0000_0155);
        probe(8'hC6, a);
        check("R11", "xar6 load", 32'(a), 32'h155);
        load_reg(4'd8, 32'hABCD_1234);
        probe(8'h40, a);
        check("R11", "sp load low half", 32'(a), 32'h1234);
        set_mode(1'b1);
        check("R11", "mode set", 32'(mode_o), 1);
        set_mode(1'b0);

        // exhaustive sweep: both maps, both sizes, all fields
        dp_i = 16'h0123;
        for (int m = 0; m < 2; m++) begin
            for (int sz = 0; sz < 2; sz++) begin
                for (int l = 0; l < 256; l++) begin
                    for (int n = 0; n < 8; n++) begin
                        bx[n] = 32'h0002_3450 + 32'(n) * 32'h0000_0101;
                        load_reg(4'(n), bx[n]);
                    end
                    bsp = 16'h0400;
                    load_reg(4'd8, {16'h0, bsp});
                    set_mode(1'(m));
                    model(1'(m), 1'(sz), 8'(l), e_vld, e_ill, e_addr, e_sp, e_x, tag);
                    issue(8'(l), 1'(sz), a, v, il);
                    check(tag, "valid", 32'(v), 32'(e_vld));
                    check(tag, "illegal", 32'(il), 32'(e_ill));
                    if (e_vld) check(tag, "address", 32'(a), 32'(e_addr));
                    tick();
                    // R10 pulses last one cycle
                    check("R10", "vld drop", 32'(addr_vld_o), 0);
                    check("R10", "ill drop", 32'(illegal_o), 0);
                    set_mode(1'b0);
                    probe(8'h40, a);
                    check(tag, "sp after", 32'(a), 32'(e_sp));
                    probe(8'hC0 | 8'(l[2:0]), a);
                    check(tag, "ptr after", 32'(a), 32'(e_x[21:0]));
                end
            end
        end

        // R12 wrap of SP and pointers
        load_reg(4'd8, 32'h0);
        issue(8'hBE, 1'b1, a, v, il);
        check("R12", "sp predec wrap addr", 32'(a), 32'hFFFE);
        probe(8'h40, a);
        check("R12", "sp predec wrap", 32'(a), 32'hFFFE);
        load_reg(4'd2, 32'h0);
        issue(8'h8A, 1'b0, a, v, il);
        check("R12", "ptr predec wrap addr", 32'(a), 32'h3F_FFFF);
        load_reg(4'd5, 32'hFFFF_FFFF);
        issue(8'h85, 1'b0, a, v, il);
        check("R12", "ptr postinc addr", 32'(a), 32'h3F_FFFF);
        probe(8'hC5, a);
        check("R12", "ptr postinc wrap", 32'(a), 0);

        // R10 no pulse without strobe
        tick();
        check("R10", "idle vld", 32'(addr_vld_o), 0);
        check("R10", "idle ill", 32'(illegal_o), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule